// File: doc/BRIEF.md
# Serial Word Transmitter

This block takes 32-bit words from a host over a 16-bit write port and stores them in a 32-entry queue. Each word arrives as two writes: the first carries the low half and the second carries the high half. The second write commits the word to the queue. While the transmit enable is high and the queue holds a word, the block takes the oldest word and sends it bit by bit on a pair of return-to-zero outputs. Bit 0 goes out first. The block waits a minimum null gap before it starts the next word.

A control input decides what bit 31 of each sent word is. It is either the host's own bit, or a parity bit computed so that the word has an odd number of ones. Another input selects one of two bit rates, both counted in cycles of the block clock. That clock is meant to be 1 MHz. Three outputs show when the queue is empty, half full and full. Converting the line levels for a real bus is done outside the block.

Top module: `serial_word_tx`

## Requirements
- R1: While `wrStb` is high at a clock edge, the block captures `wrData`. Writes alternate between the two halves, starting with the low half after reset. The first write sets word bits 15:0 and the second sets bits 31:16. The second write enqueues the assembled word. Word bit 0 is transmitted first and bit 31 last.
- R2: The queue holds up to 32 words and sends them in the order they were written.
- R3: `fifoEmpty` is high when the queue holds 0 words. `fifoHalf` is high when it holds 16 or more. `fifoFull` is high when it holds 32. All three flags follow the count one clock after the edge at which a write or a start changed it. After reset the count is 0.
- R4: If the second-half write arrives while the queue is full, it is discarded. The count stays at 32, and the next write is again taken as a low half.
- R5: `parityMode` is sampled when a word is taken from the queue. If it is 1, bit 31 is sent as the inverse XOR of bits 30:0, so the word has an odd number of ones. If it is 0, bit 31 is sent as written.
- R6: Each bit cell lasts N clocks. For the first N/2 clocks the line shows the bit: `lineHi` high for a 1, `lineLo` high for a 0. For the remaining clocks both lines are low. Both lines are also low when idle, and they are never high together.
- R7: `rateSlow` is sampled at word start. A value of 0 gives N = 10 clocks per bit and a value of 1 gives N = 80.
- R8: A word starts at an edge where `txEnable` is high and the queue is not empty. Its first cell begins in the next cycle. A word that has started is always sent in full, even if `txEnable` falls.
- R9: After the last cell of a word, the line stays null for 4·N clocks plus one more idle clock before the next start can happen. When words are sent back to back at N = 10, the null run between them is 46 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-timing clock (nominally 1 MHz) |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Half-word write strobe |
| wrData | input | 16 | Half-word write data |
| parityMode | input | 1 | 1 = generate parity in bit 31, 0 = pass bit 31 through |
| rateSlow | input | 1 | 1 = 80 clocks per bit, 0 = 10 clocks per bit |
| txEnable | input | 1 | Allows new words to start |
| lineHi | output | 1 | Return-to-zero "one" line |
| lineLo | output | 1 | Return-to-zero "zero" line |
| fifoEmpty | output | 1 | Queue holds no words |
| fifoHalf | output | 1 | Queue holds 16 or more words |
| fifoFull | output | 1 | Queue holds 32 words |

## Verification
The minimum-gap property uses the fast cell length as its lower bound, so it assumes both rates are at least that long. The properties also assume reset is held low for at least one edge before it is released. The bench changes `rateSlow` and `parityMode` only while no word is being sent, because the model samples them exactly at word start. Writes are always made in full low-then-high pairs. The full-queue case is tested by a complete pair whose second half lands on a full queue.

// File: rtl/swtx_pkg.sv
package swtx_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // take head word into shifter
    logic shift;  // advance to next bit
    logic drive;  // line shows data (first half of cell)
  } txStrb_t;
endpackage

// File: rtl/swtx_datapath.sv
module swtx_datapath #(
  parameter int BUS_W  = 16,
  parameter int WORD_W = 2 * BUS_W,
  parameter int DEPTH  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrStb,
  input  logic [BUS_W-1:0]     wrData,
  input  logic                 parityMode,
  input  swtx_pkg::txStrb_t    strb,
  output logic                 fifoEmpty,
  output logic                 fifoHalf,
  output logic                 fifoFull,
  output logic                 lineHi,
  output logic                 lineLo
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF_MARK = DEPTH / 2;

  logic [BUS_W-1:0]  loHalf;
  logic              halfPend;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [WORD_W-1:0] headWord;
  logic [WORD_W-1:0] shReg;
  logic              push, pop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign fifoEmpty = (count == '0);
  assign fifoHalf  = (count >= CNT_W'(HALF_MARK));
  assign fifoFull  = (count == CNT_W'(DEPTH));

  assign push = wrStb && halfPend && !fifoFull;
  assign pop  = strb.load;

  // Half-word assembly
  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfPend <= 1'b0;
      loHalf   <= '0;
    end else if (wrStb) begin
      halfPend <= !halfPend;
      if (!halfPend) loHalf <= wrData;
    end
  end

  // Queue storage
  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {wrData, loHalf};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Bit 31 selection at load time
  always_comb begin
    headWord = mem[rdPtr];
    if (parityMode) headWord[WORD_W-1] = ~(^headWord[WORD_W-2:0]);
  end

  // Output shifter, LSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (strb.load) begin
      shReg <= headWord;
    end else if (strb.shift) begin
      shReg <= {1'b0, shReg[WORD_W-1:1]};
    end
  end

  assign lineHi = strb.drive &  shReg[0];
  assign lineLo = strb.drive & ~shReg[0];
endmodule

// File: rtl/swtx_ctrl.sv
module swtx_ctrl #(
  parameter int WORD_W    = 32,
  parameter int FAST_CELL = 10,
  parameter int SLOW_CELL = 80,
  parameter int GAP_BITS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              rateSlow,
  input  logic              fifoEmpty,
  output swtx_pkg::txStrb_t strb
);
  localparam int CELL_W  = $clog2(SLOW_CELL + 1);
  localparam int GAP_MAX = GAP_BITS * SLOW_CELL;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int BIT_W   = $clog2(WORD_W);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} txState_t;

  txState_t          state;
  logic [CELL_W-1:0] cellLen;
  logic [CELL_W-1:0] phase;
  logic [BIT_W-1:0]  bitIdx;
  logic [GAP_W-1:0]  gapCnt;
  logic [GAP_W-1:0]  gapLast;
  logic              cellEnd, lastBit, gapEnd, startNow;

  assign gapLast  = GAP_W'(GAP_BITS) * GAP_W'(cellLen) - GAP_W'(1);
  assign cellEnd  = (phase == cellLen - CELL_W'(1));
  assign lastBit  = (bitIdx == BIT_W'(WORD_W - 1));
  assign gapEnd   = (gapCnt == gapLast);
  assign startNow = (state == ST_IDLE) && txEnable && !fifoEmpty;

  always_comb begin
    strb.load  = startNow;
    strb.shift = (state == ST_SEND) && cellEnd;
    strb.drive = (state == ST_SEND) && (phase < (cellLen >> 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cellLen <= CELL_W'(FAST_CELL);
      phase   <= '0;
      bitIdx  <= '0;
      gapCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startNow) begin
            state   <= ST_SEND;
            cellLen <= rateSlow ? CELL_W'(SLOW_CELL) : CELL_W'(FAST_CELL);
            phase   <= '0;
            bitIdx  <= '0;
          end
        end
        ST_SEND: begin
          if (cellEnd) begin
            phase <= '0;
            if (lastBit) begin
              state  <= ST_GAP;
              gapCnt <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapEnd) state <= ST_IDLE;
          else        gapCnt <= gapCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx #(
  parameter int BUS_W     = 16,
  parameter int DEPTH     = 32,
  parameter int FAST_CELL = 10,
  parameter int SLOW_CELL = 80,
  parameter int GAP_BITS  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStb,
  input  logic [BUS_W-1:0] wrData,
  input  logic             parityMode,
  input  logic             rateSlow,
  input  logic             txEnable,
  output logic             lineHi,
  output logic             lineLo,
  output logic             fifoEmpty,
  output logic             fifoHalf,
  output logic             fifoFull
);
  localparam int WORD_W = 2 * BUS_W;

  swtx_pkg::txStrb_t ctlStrb;

  swtx_ctrl #(
    .WORD_W(WORD_W), .FAST_CELL(FAST_CELL),
    .SLOW_CELL(SLOW_CELL), .GAP_BITS(GAP_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .rateSlow(rateSlow),
    .fifoEmpty(fifoEmpty), .strb(ctlStrb)
  );

  swtx_datapath #(
    .BUS_W(BUS_W), .WORD_W(WORD_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData),
    .parityMode(parityMode), .strb(ctlStrb),
    .fifoEmpty(fifoEmpty), .fifoHalf(fifoHalf), .fifoFull(fifoFull),
    .lineHi(lineHi), .lineLo(lineLo)
  );
endmodule

// File: rtl/swtx_checker.sv
module swtx_checker #(
  parameter int FAST_CELL = 10,
  parameter int GAP_BITS  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              txEnable,
  input logic              lineHi,
  input logic              lineLo,
  input logic              fifoEmpty,
  input logic              fifoHalf,
  input logic              fifoFull,
  input swtx_pkg::txStrb_t strb
);
  logic [15:0] sinceDrive;
  logic        seenWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceDrive <= '0;
      seenWord   <= 1'b0;
    end else begin
      if (lineHi || lineLo)         sinceDrive <= '0;
      else if (sinceDrive != '1)    sinceDrive <= sinceDrive + 1'b1;
      if (strb.load)                seenWord   <= 1'b1;
    end
  end

  a_r6_rz_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(lineHi && lineLo));

  a_r3_full_implies_half: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> (fifoHalf && !fifoEmpty));

  a_r3_empty_not_half: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !fifoHalf);

  a_r8_start_gate: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (txEnable && !fifoEmpty));

  a_r4_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !strb.load) |=> fifoFull);

  a_r9_min_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && seenWord) |-> (int'(sinceDrive) >= GAP_BITS * FAST_CELL));
endmodule

bind serial_word_tx swtx_checker #(
  .FAST_CELL(FAST_CELL), .GAP_BITS(GAP_BITS)
) u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .lineHi(lineHi),
  .lineLo(lineLo), .fifoEmpty(fifoEmpty), .fifoHalf(fifoHalf),
  .fifoFull(fifoFull), .strb(ctlStrb)
);

// File: tb/serial_word_tx_tb.sv
module serial_word_tx_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] wrData = '0;
  logic        parityMode = 1'b0;
  logic        rateSlow = 1'b0;
  logic        txEnable = 1'b0;
  logic        lineHi, lineLo, fifoEmpty, fifoHalf, fifoFull;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  serial_word_tx u_dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData),
    .parityMode(parityMode), .rateSlow(rateSlow), .txEnable(txEnable),
    .lineHi(lineHi), .lineLo(lineLo), .fifoEmpty(fifoEmpty),
    .fifoHalf(fifoHalf), .fifoFull(fifoFull)
  );

  // Reference model state
  logic [31:0] mq[$];
  bit          mHalf;
  logic [15:0] mLo;
  int          mSt, mBit, mPh, mGap, mCell;
  logic [31:0] mCur;

  // Line decoder state
  logic [31:0] dq[$];
  logic [31:0] dW = '0;
  int          dN = 0;
  bit          pHi = 0, pLo = 0;
  int          runOn = 0, runOff = 0, lastPulse = 0, lastGap = 0, wordsSeen = 0;

  logic [31:0] expList[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit popNow, pushNow, eHi, eLo;
    logic [31:0] pw, w;
    popNow = 0; pushNow = 0; pw = '0; w = '0;
    if (!rstN) begin
      mq.delete(); mHalf = 0; mLo = '0; mSt = 0; mBit = 0; mPh = 0;
      mGap = 0; mCell = 10; mCur = '0;
    end else begin
      case (mSt)
        0: if (txEnable && mq.size() > 0) popNow = 1;
        1: begin
          if (mPh == mCell - 1) begin
            mPh = 0;
            if (mBit == 31) begin mSt = 2; mGap = 0; end
            else mBit++;
          end else mPh++;
        end
        default: begin
          if (mGap == 4 * mCell - 1) mSt = 0;
          else mGap++;
        end
      endcase
      if (wrStb) begin
        if (!mHalf) begin mLo = wrData; mHalf = 1; end
        else begin
          mHalf = 0;
          if (mq.size() < 32) begin pushNow = 1; pw = {wrData, mLo}; end
        end
      end
      if (popNow) begin
        w = mq.pop_front();
        if (parityMode) w[31] = ~(^w[30:0]);
        mCur = w; mSt = 1; mBit = 0; mPh = 0;
        mCell = rateSlow ? 80 : 10;
      end
      if (pushNow) mq.push_back(pw);
    end
    #5;
    eHi = (mSt == 1) && (mPh < mCell / 2) && mCur[mBit];
    eLo = (mSt == 1) && (mPh < mCell / 2) && !mCur[mBit];
    if (rstN) begin
      chk(lineHi == eHi && lineLo == eLo, "R6 line pair", {30'd0, lineHi, lineLo}, {30'd0, eHi, eLo});
      chk(fifoEmpty == (mq.size() == 0) && fifoHalf == (mq.size() >= 16) && fifoFull == (mq.size() == 32),
          "R3 flags", {29'd0, fifoEmpty, fifoHalf, fifoFull},
          {29'd0, mq.size() == 0, mq.size() >= 16, mq.size() == 32});
      if ((lineHi && !pHi) || (lineLo && !pLo)) begin
        if (dN == 0 && wordsSeen > 0) lastGap = runOff;
        dW = {lineHi, dW[31:1]};
        dN++;
        if (dN == 32) begin dq.push_back(dW); dN = 0; wordsSeen++; end
      end
      if (lineHi || lineLo) begin runOn++; runOff = 0; end
      else begin
        if (runOn > 0) lastPulse = runOn;
        runOn = 0; runOff++;
      end
      pHi = lineHi; pLo = lineLo;
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); wrData = d; wrStb = 1'b1;
    @(negedge clk); wrStb = 1'b0;
  endtask

  task automatic writeWord(input logic [31:0] w);
    wr(w[15:0]);
    wr(w[31:16]);
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin @(negedge clk); n++; end
    while (!(mSt == 0 && mq.size() == 0 && dN == 0) && n < 20000);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000000) @(posedge clk);
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    // R3: reset state
    chk(!lineHi && !lineLo && fifoEmpty && !fifoHalf && !fifoFull, "R3 reset state",
        {27'd0, lineHi, lineLo, fifoEmpty, fifoHalf, fifoFull}, 32'h4);
    rstN = 1'b1;

    // R2/R3: fill with transmitter disabled
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = {16'(i * 16'h0313 + 16'h0101), 16'(i ^ 16'hA55A)};
      if (i == 5) w[31] = 1'b1;
      expList.push_back(w);
      writeWord(w);
      if (i == 15) begin
        @(negedge clk);
        chk(fifoHalf && !fifoFull, "R3 half at 16", {30'd0, fifoHalf, fifoFull}, 32'h2);
      end
    end
    @(negedge clk);
    chk(fifoFull, "R2 full at 32", {31'd0, fifoFull}, 32'h1);
    writeWord(32'hDEAD_BEEF);
    @(negedge clk);
    chk(fifoFull, "R4 full after dropped write", {31'd0, fifoFull}, 32'h1);

    // R1/R2: drain at fast rate, bit 31 passed through
    txEnable = 1'b1;
    waitIdle();
    txEnable = 1'b0;
    chk(dq.size() == 32, "R4 dropped word absent", dq.size(), 32);
    for (int i = 0; i < 32 && i < dq.size(); i++)
      chk(dq[i] == expList[i], "R1 R2 word order and bits", dq[i], expList[i]);
    chk(lastPulse == 5, "R6 data half of fast cell", lastPulse, 5);
    chk(lastGap == 46, "R9 null run between words", lastGap, 46);
    dq.delete();

    // R4: writer returns to low half after the dropped pair
    writeWord(32'h1357_2468);
    txEnable = 1'b1; waitIdle(); txEnable = 1'b0;
    got = (dq.size() > 0) ? dq[0] : 32'hFFFF_FFFF;
    chk(got == 32'h1357_2468, "R4 half pointer realigned", got, 32'h1357_2468);
    dq.delete();

    // R5: parity generation and pass-through
    parityMode = 1'b1;
    writeWord(32'h0000_0003);
    writeWord(32'h8000_0007);
    txEnable = 1'b1; waitIdle(); txEnable = 1'b0;
    got = (dq.size() > 0) ? dq[0] : 32'hFFFF_FFFF;
    chk(got == 32'h8000_0003, "R5 parity set", got, 32'h8000_0003);
    got = (dq.size() > 1) ? dq[1] : 32'hFFFF_FFFF;
    chk(got == 32'h0000_0007, "R5 parity cleared", got, 32'h0000_0007);
    dq.delete();
    parityMode = 1'b0;
    writeWord(32'h8000_0001);
    txEnable = 1'b1; waitIdle(); txEnable = 1'b0;
    got = (dq.size() > 0) ? dq[0] : 32'hFFFF_FFFF;
    chk(got == 32'h8000_0001, "R5 pass-through bit 31", got, 32'h8000_0001);
    dq.delete();

    // R7: slow rate
    rateSlow = 1'b1;
    writeWord(32'h1234_5678);
    txEnable = 1'b1; waitIdle(); txEnable = 1'b0;
    got = (dq.size() > 0) ? dq[0] : 32'hFFFF_FFFF;
    chk(got == 32'h1234_5678, "R7 slow word", got, 32'h1234_5678);
    chk(lastPulse == 40, "R7 data half of slow cell", lastPulse, 40);
    dq.delete();
    rateSlow = 1'b0;

    // R8: no start while disabled; started word finishes
    writeWord(32'h0F0F_F0F0);
    repeat (100) @(negedge clk);
    chk(!lineHi && !lineLo && !fifoEmpty, "R8 held while disabled",
        {29'd0, lineHi, lineLo, fifoEmpty}, 32'h0);
    txEnable = 1'b1;
    repeat (30) @(negedge clk);
    txEnable = 1'b0;
    waitIdle();
    got = (dq.size() > 0) ? dq[0] : 32'hFFFF_FFFF;
    chk(got == 32'h0F0F_F0F0, "R8 word completes after enable drop", got, 32'h0F0F_F0F0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule